// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave with Address Guard

This block models a serial EEPROM slave. A host drives it over a chip select, a serial clock and a serial data input. Each frame carries a start bit, a two-bit operation code and an eight-bit address field, followed by data bits when the command needs them. Storage is a 128 x 16 word array. The serial output is tri-state and is modelled as a data bit plus an enable. It returns read data and, after a programming command, a busy/ready status bit. The whole block runs on one system clock; the serial clock and select lines are sampled as ordinary inputs, and the block acts on the serial clock's rising edges.

A second control input, the guard select, redirects the command set to an address guard register. When the guard is active, array writes at or above a stored boundary address are refused. The guard must be armed before each change. It can be set, cleared or locked off for good, and its contents can be read back. Programming commands take effect when the select line falls at the end of a complete frame. A timer then holds the block busy for a parameterised number of clocks.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, and on the first clock after the select line is low, the output enable is low. After reset the array holds all zeros, the guard boundary is 7'h7F and the guard is inactive.
- R2: The block acts only on rising serial-clock edges while selected. Zero bits before the first 1 are ignored. The first 1 is the start bit. The next ten bits are the operation code and then the address, each sent MSB first.
- R3: With guard select low, operation 2'b10 reads a word. After the last address bit the output shows a 0. The word's 16 bits then follow, MSB first, one per rising edge. On the next edge the output is released. Address bit 7 is ignored.
- R4: With guard select low, operation 2'b01 writes the 16 data bits that follow (MSB first) to the addressed word. Address bit 7 is ignored. The write happens only if the select line falls after all 16 data bits, a write-enable command (operation 2'b00, address 2'b11 in bits 7:6) came earlier, and the program-enable input is high at that fall. A write-disable command (operation 2'b00, bits 7:6 = 2'b00) blocks later writes.
- R5: With guard select low, operation 2'b00 with address bits 7:6 = 2'b01 writes the 16 data bits that follow into every word. It needs the same enables as R4 and is refused while the guard is active.
- R6: An accepted programming command makes the block busy for WR_CYCLES clocks. Raising the select line without sending a start bit then drives 0 while busy and 1 once ready. Start bits received while busy are ignored.
- R7: If the select line falls before a frame is complete, no state changes.
- R8: With guard select high, operation 2'b00 with address bits 7:6 = 2'b11 arms the guard. This needs no enables. Every set, clear or lock needs the guard to be armed, a write-enable and program-enable high, and it uses up the arming.
- R9: With guard select high, operation 2'b01 loads address bits 6:0 as the boundary and makes the guard active. No data bits follow. While the guard is active, writes to any address at or above the boundary are dropped.
- R10: With guard select high, operation 2'b10 outputs a 0 and then 8 bits, {active, boundary[6:0]}, MSB first. The output is then released.
- R11: With guard select high, operation 2'b11 with address 8'hFF makes the guard inactive and sets the boundary to 7'h7F.
- R12: With guard select high, operation 2'b00 with address 8'h00 locks the guard for good and makes it inactive. After that, every arm, set or clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| chip_sel | input | 1 | Select line, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command and data input |
| prog_en | input | 1 | Program enable, must be high for any array or guard change |
| guard_sel | input | 1 | Redirects commands to the address guard register |
| ser_out | output | 1 | Serial data or status bit |
| ser_out_en | output | 1 | Drive enable for ser_out (low means high impedance) |

## Verification
The checks assume that the serial clock and select line change well away from the system clock edge. They also assume the serial clock holds each level for several system clocks, so every serial edge is seen exactly once. The bench drives all inputs on the falling system clock edge and holds each serial level for at least four system clocks. It keeps the select line low on a serial-clock low phase, so a fall of the select line never coincides with a rising serial edge. The bench allows no frame to last as long as the programming time, so a start bit sent while busy cannot turn into a late start in the middle of the same frame.

// File: rtl/mw_pkg.sv
package mw_pkg;

   // width of the address field in every frame; decoding depends on it
   localparam int MW_AFIELD = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_SEND,
      ST_DONE
   } st_t;

   typedef enum logic [3:0] {
      K_NONE,
      K_WEN,
      K_WDS,
      K_WRITE,
      K_WRALL,
      K_READ,
      K_GARM,
      K_GSET,
      K_GOFF,
      K_GCLR,
      K_GREAD
   } kind_t;

   function automatic kind_t mw_decode(input logic [1:0] op,
                                       input logic [MW_AFIELD-1:0] a,
                                       input logic g);
      kind_t k;
      k = K_NONE;
      if (!g) begin
         case (op)
            2'b10: k = K_READ;
            2'b01: k = K_WRITE;
            2'b00: begin
               case (a[MW_AFIELD-1 -: 2])
                  2'b11:   k = K_WEN;
                  2'b00:   k = K_WDS;
                  2'b01:   k = K_WRALL;
                  default: k = K_NONE;
               endcase
            end
            default: k = K_NONE;
         endcase
      end else begin
         case (op)
            2'b10: k = K_GREAD;
            2'b01: k = K_GSET;
            2'b00: begin
               if (a[MW_AFIELD-1 -: 2] == 2'b11) k = K_GARM;
               else if (a == '0)                 k = K_GOFF;
               else                              k = K_NONE;
            end
            default: k = (a == '1) ? K_GCLR : K_NONE;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/mw_timer.sv
module mw_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(CYCLES + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= TW'(CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              fill,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (fill) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mw_guard.sv
module mw_guard #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_arm,
   input  logic              do_set,
   input  logic              do_clr,
   input  logic              do_lock,
   input  logic [ADDR_W-1:0] val_in,
   output logic [ADDR_W-1:0] g_val,
   output logic              g_act,
   output logic              g_arm,
   output logic              g_lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_val  <= '1;
         g_act  <= 1'b0;
         g_arm  <= 1'b0;
         g_lock <= 1'b0;
      end else if (do_lock) begin
         g_lock <= 1'b1;
         g_act  <= 1'b0;
         g_arm  <= 1'b0;
      end else if (do_clr) begin
         g_val  <= '1;
         g_act  <= 1'b0;
         g_arm  <= 1'b0;
      end else if (do_set) begin
         g_val  <= val_in;
         g_act  <= 1'b1;
         g_arm  <= 1'b0;
      end else if (do_arm) begin
         g_arm  <= 1'b1;
      end
   end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 16,
   parameter int WR_CYCLES = 200,
   parameter bit HAS_GUARD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic ser_clk,
   input  logic ser_in,
   input  logic prog_en,
   input  logic guard_sel,
   output logic ser_out,
   output logic ser_out_en
);
   localparam int HDR_W  = 2 + MW_AFIELD;
   localparam int SEND_W = DATA_W + 1;
   localparam int CNT_W  = $clog2(SEND_W + HDR_W + 1);
   localparam int GPAD   = SEND_W - ADDR_W - 2;

   if (ADDR_W < 1 || ADDR_W > MW_AFIELD - 1) begin : g_bad_addr
      $error("ADDR_W must lie in 1..%0d", MW_AFIELD - 1);
   end
   if (DATA_W < ADDR_W + 2) begin : g_bad_data
      $error("DATA_W must be at least ADDR_W+2");
   end
   if (WR_CYCLES < 1) begin : g_bad_cyc
      $error("WR_CYCLES must be positive");
   end

   st_t               st_q;
   kind_t             kind_q, kind_nx;
   logic [CNT_W-1:0]  cnt_q, left_q;
   logic [HDR_W-1:0]  hdr_q, hdr_nx;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dat_q, rdata;
   logic [SEND_W-1:0] snd_q;
   logic              sk_q, cs_q, wen_q, poll_q, out_q, oe_q;
   logic              rise, cs_fall, commit, ok_prog, prot_hit, g_ok;
   logic              mem_we, mem_fill, tmr_start, tmr_busy;
   logic              g_do_arm, g_do_set, g_do_clr, g_do_lock;
   logic [ADDR_W-1:0] g_val;
   logic              g_act, g_arm, g_lock;

   assign rise    = chip_sel & ser_clk & ~sk_q;
   assign cs_fall = cs_q & ~chip_sel;
   assign commit  = cs_fall && (st_q == ST_DONE);
   assign hdr_nx  = {hdr_q[HDR_W-2:0], ser_in};
   assign kind_nx = mw_decode(hdr_nx[HDR_W-1 -: 2], hdr_nx[MW_AFIELD-1:0],
                              guard_sel & HAS_GUARD);

   // commit-time gating of every state change
   assign ok_prog   = wen_q & prog_en;
   assign prot_hit  = g_act && (addr_q >= g_val);
   assign g_ok      = ok_prog & g_arm & ~g_lock;
   assign mem_we    = commit && (kind_q == K_WRITE) && ok_prog && !prot_hit;
   assign mem_fill  = commit && (kind_q == K_WRALL) && ok_prog && !g_act;
   assign g_do_arm  = commit && (kind_q == K_GARM) && !g_lock;
   assign g_do_set  = commit && (kind_q == K_GSET) && g_ok;
   assign g_do_clr  = commit && (kind_q == K_GCLR) && g_ok;
   assign g_do_lock = commit && (kind_q == K_GOFF) && g_ok;
   assign tmr_start = mem_we | mem_fill | g_do_set | g_do_clr | g_do_lock;

   mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .fill  (mem_fill),
      .waddr (addr_q),
      .wdata (dat_q),
      .raddr (hdr_nx[ADDR_W-1:0]),
      .rdata (rdata)
   );

   mw_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .busy  (tmr_busy)
   );

   if (HAS_GUARD) begin : g_guard
      mw_guard #(.ADDR_W(ADDR_W)) u_guard (
         .clk     (clk),
         .rst_n   (rst_n),
         .do_arm  (g_do_arm),
         .do_set  (g_do_set),
         .do_clr  (g_do_clr),
         .do_lock (g_do_lock),
         .val_in  (addr_q),
         .g_val   (g_val),
         .g_act   (g_act),
         .g_arm   (g_arm),
         .g_lock  (g_lock)
      );
   end else begin : g_noguard
      assign g_val  = '1;
      assign g_act  = 1'b0;
      assign g_arm  = 1'b0;
      assign g_lock = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= K_NONE;
         cnt_q  <= '0;
         left_q <= '0;
         hdr_q  <= '0;
         addr_q <= '0;
         dat_q  <= '0;
         snd_q  <= '0;
         sk_q   <= 1'b0;
         cs_q   <= 1'b0;
         wen_q  <= 1'b0;
         poll_q <= 1'b0;
      end else begin
         sk_q <= ser_clk;
         cs_q <= chip_sel;
         if (!chip_sel) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            left_q <= '0;
         end else if (rise) begin
            case (st_q)
               ST_IDLE: begin
                  if (ser_in && !tmr_busy) begin
                     st_q   <= ST_HDR;
                     cnt_q  <= '0;
                     poll_q <= 1'b0;
                  end
               end
               ST_HDR: begin
                  hdr_q <= hdr_nx;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(HDR_W - 1)) begin
                     kind_q <= kind_nx;
                     addr_q <= hdr_nx[ADDR_W-1:0];
                     cnt_q  <= '0;
                     case (kind_nx)
                        K_READ: begin
                           st_q   <= ST_SEND;
                           snd_q  <= {1'b0, rdata};
                           left_q <= CNT_W'(SEND_W);
                        end
                        K_GREAD: begin
                           st_q   <= ST_SEND;
                           snd_q  <= {1'b0, g_act, g_val, {GPAD{1'b0}}};
                           left_q <= CNT_W'(ADDR_W + 2);
                        end
                        K_WRITE, K_WRALL: st_q <= ST_DATA;
                        default:          st_q <= ST_DONE;
                     endcase
                  end
               end
               ST_DATA: begin
                  dat_q <= {dat_q[DATA_W-2:0], ser_in};
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(DATA_W - 1)) st_q <= ST_DONE;
               end
               ST_SEND: begin
                  snd_q  <= {snd_q[SEND_W-2:0], 1'b0};
                  left_q <= left_q - 1'b1;
                  if (left_q == CNT_W'(1)) st_q <= ST_DONE;
               end
               default: ;
            endcase
         end
         if (commit && kind_q == K_WEN) wen_q <= 1'b1;
         if (commit && kind_q == K_WDS) wen_q <= 1'b0;
         if (tmr_start)                 poll_q <= 1'b1;
      end
   end

   // registered output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         out_q <= 1'b0;
      end else begin
         oe_q  <= chip_sel && ((st_q == ST_SEND) || (st_q == ST_IDLE && poll_q));
         out_q <= (st_q == ST_SEND) ? snd_q[SEND_W-1] : ~tmr_busy;
      end
   end

   assign ser_out    = out_q;
   assign ser_out_en = oe_q;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
   import mw_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_sel,
   input logic              prog_en,
   input logic              ser_out,
   input logic              ser_out_en,
   input st_t               st_q,
   input logic              tmr_busy,
   input logic              tmr_start,
   input logic              mem_we,
   input logic              mem_fill,
   input logic              wen_q,
   input logic [ADDR_W-1:0] g_val,
   input logic              g_act,
   input logic              g_lock
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |=> !ser_out_en);

   // R4
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_fill) |-> (wen_q && prog_en));

   // R6
   busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_out_en && $past(st_q) == ST_IDLE && $past(tmr_busy)) |-> !ser_out);

   // R6
   no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_busy && st_q == ST_IDLE) |=> (st_q == ST_IDLE));

   // R6
   busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_busy) |-> $past(tmr_start));

   // R7
   commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_fill) |-> (st_q == ST_DONE && !chip_sel));

   // R12
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_lock |=> g_lock);

   // R12
   lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_lock |=> ($stable(g_val) && !g_act));
endmodule

bind mw_eeprom mw_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_sel   (chip_sel),
   .prog_en    (prog_en),
   .ser_out    (ser_out),
   .ser_out_en (ser_out_en),
   .st_q       (st_q),
   .tmr_busy   (tmr_busy),
   .tmr_start  (tmr_start),
   .mem_we     (mem_we),
   .mem_fill   (mem_fill),
   .wen_q      (wen_q),
   .g_val      (g_val),
   .g_act      (g_act),
   .g_lock     (g_lock)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
   localparam int CLK_T = 10;
   localparam int WRC   = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
   logic prog_en = 1'b1, guard_sel = 1'b0;
   logic ser_out, ser_out_en;

   int total = 0;
   int bad = 0;

   typedef struct {
      logic [15:0] v;
      string       tag;
   } item_t;

   item_t exp_q[$];
   logic [15:0] act_q[$];
   event got_ev;

   always #(CLK_T/2) clk = ~clk;

   mw_eeprom #(.WR_CYCLES(WRC)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel   (chip_sel),
      .ser_clk    (ser_clk),
      .ser_in     (ser_in),
      .prog_en    (prog_en),
      .guard_sel  (guard_sel),
      .ser_out    (ser_out),
      .ser_out_en (ser_out_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(got_ev);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            logic [15:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            chk(e.tag, {16'h0, a}, {16'h0, e.v});
         end
      end
   end

   task automatic sbit(input logic b);
      @(negedge clk);
      ser_in  = b;
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, input int lead);
      @(negedge clk);
      chip_sel = 1'b1;
      for (int i = 0; i < lead; i++) sbit(1'b0);
      sbit(1'b1);
      for (int i = 1; i >= 0; i--) sbit(op[i]);
      for (int i = 7; i >= 0; i--) sbit(a[i]);
   endtask

   task automatic end_cmd();
      @(negedge clk);
      ser_clk  = 1'b0;
      chip_sel = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic cmd_nd(input logic [1:0] op, input logic [7:0] a);
      send_hdr(op, a, 0);
      end_cmd();
   endtask

   task automatic cmd_d(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
      send_hdr(op, a, 0);
      for (int i = 15; i >= 0; i--) sbit(d[i]);
      end_cmd();
   endtask

   task automatic read_word(input logic [7:0] a, input logic [15:0] exp,
                            input int lead, input string tag);
      logic [15:0] w;
      item_t it;
      it.v = exp;
      it.tag = tag;
      exp_q.push_back(it);
      send_hdr(2'b10, a, lead);
      chk({tag, " dummy"}, {30'h0, ser_out_en, ser_out}, 32'h2);
      for (int i = 15; i >= 0; i--) begin
         sbit(1'b0);
         w[i] = ser_out;
      end
      sbit(1'b0);
      chk("R3 released after word", {31'h0, ser_out_en}, 32'h0);
      end_cmd();
      act_q.push_back(w);
      ->got_ev;
   endtask

   task automatic read_guard(input logic [7:0] exp, input string tag);
      logic [7:0] w;
      item_t it;
      it.v = {8'h0, exp};
      it.tag = tag;
      exp_q.push_back(it);
      guard_sel = 1'b1;
      send_hdr(2'b10, 8'h00, 0);
      chk("R10 dummy", {30'h0, ser_out_en, ser_out}, 32'h2);
      for (int i = 7; i >= 0; i--) begin
         sbit(1'b0);
         w[i] = ser_out;
      end
      sbit(1'b0);
      chk("R10 released after byte", {31'h0, ser_out_en}, 32'h0);
      end_cmd();
      act_q.push_back({8'h0, w});
      ->got_ev;
   endtask

   task automatic wait_ready(input string tag);
      int n;
      @(negedge clk);
      chip_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk({tag, " busy"}, {30'h0, ser_out_en, ser_out}, 32'h2);
      n = 0;
      while (ser_out !== 1'b1 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " ready"}, {30'h0, ser_out_en, ser_out}, 32'h3);
      chip_sel = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic no_busy(input string tag);
      @(negedge clk);
      chip_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk(tag, {31'h0, ser_out_en}, 32'h0);
      chip_sel = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 output released after reset", {31'h0, ser_out_en}, 32'h0);
      read_word(8'h05, 16'h0000, 0, "R1 array cleared");
      read_guard(8'h7F, "R1 guard reset value");

      // R4 write without enable is dropped
      guard_sel = 1'b0;
      cmd_d(2'b01, 8'h05, 16'hA5C3);
      no_busy("R4 no busy without enable");
      read_word(8'h05, 16'h0000, 0, "R4 write needs enable");

      // R4 enable then write, R6 busy/ready
      cmd_nd(2'b00, 8'hC0);
      cmd_d(2'b01, 8'h05, 16'hA5C3);
      wait_ready("R6 after write");
      read_word(8'h05, 16'hA5C3, 2, "R2 leading zeros before start");
      read_word(8'h05, 16'hA5C3, 0, "R3 read word");

      // R4 / R3 top address bit ignored
      cmd_d(2'b01, 8'h85, 16'h1234);
      wait_ready("R6 after write 85");
      read_word(8'h05, 16'h1234, 0, "R4 A7 ignored on write");
      read_word(8'h85, 16'h1234, 0, "R3 A7 ignored on read");

      // R6 commands ignored while busy
      cmd_d(2'b01, 8'h07, 16'h1111);
      cmd_d(2'b01, 8'h07, 16'h2222);
      wait_ready("R6 busy ignore");
      read_word(8'h07, 16'h1111, 0, "R6 command during busy ignored");

      // R4 program enable low
      prog_en = 1'b0;
      cmd_d(2'b01, 8'h05, 16'hFFFF);
      prog_en = 1'b1;
      read_word(8'h05, 16'h1234, 0, "R4 prog_en low drops write");

      // R7 aborts
      @(negedge clk);
      chip_sel = 1'b1;
      sbit(1'b1);
      sbit(1'b0);
      sbit(1'b1);
      for (int i = 0; i < 4; i++) sbit(1'b0);
      end_cmd();
      send_hdr(2'b01, 8'h05, 0);
      for (int i = 0; i < 15; i++) sbit(1'b1);
      end_cmd();
      no_busy("R7 aborted frame no busy");
      read_word(8'h05, 16'h1234, 0, "R7 aborted write");

      // R5 write all
      cmd_d(2'b00, 8'h40, 16'hBEEF);
      wait_ready("R5 write all");
      read_word(8'h00, 16'hBEEF, 0, "R5 word 0");
      read_word(8'h7F, 16'hBEEF, 0, "R5 word 127");

      // R8 set without arming ignored
      guard_sel = 1'b1;
      cmd_nd(2'b01, 8'h40);
      read_guard(8'h7F, "R8 set needs arming");

      // R9 arm + set boundary 0x40
      guard_sel = 1'b1;
      cmd_nd(2'b00, 8'hC0);
      cmd_nd(2'b01, 8'h40);
      wait_ready("R9 guard set");
      read_guard(8'hC0, "R10 guard read active");
      guard_sel = 1'b0;
      cmd_d(2'b01, 8'h40, 16'h1111);
      read_word(8'h40, 16'hBEEF, 0, "R9 write at boundary dropped");
      cmd_d(2'b01, 8'h3F, 16'h3333);
      wait_ready("R9 below boundary");
      read_word(8'h3F, 16'h3333, 0, "R9 write below boundary");
      cmd_d(2'b00, 8'h40, 16'h0000);
      read_word(8'h00, 16'hBEEF, 0, "R5 write all refused while guarded");

      // R8 arming used up
      guard_sel = 1'b1;
      cmd_nd(2'b01, 8'h10);
      read_guard(8'hC0, "R8 arming consumed");

      // R11 clear
      guard_sel = 1'b1;
      cmd_nd(2'b00, 8'hC0);
      cmd_nd(2'b11, 8'hFF);
      wait_ready("R11 guard clear");
      read_guard(8'h7F, "R11 guard cleared");
      guard_sel = 1'b0;
      cmd_d(2'b01, 8'h40, 16'h4444);
      wait_ready("R11 write after clear");
      read_word(8'h40, 16'h4444, 0, "R11 write after clear");

      // R4 write disable
      cmd_nd(2'b00, 8'h00);
      cmd_d(2'b01, 8'h09, 16'h5555);
      read_word(8'h09, 16'hBEEF, 0, "R4 write disabled");
      cmd_nd(2'b00, 8'hC0);

      // R12 lock
      guard_sel = 1'b1;
      cmd_nd(2'b00, 8'hC0);
      cmd_nd(2'b00, 8'h00);
      wait_ready("R12 lock");
      guard_sel = 1'b1;
      cmd_nd(2'b00, 8'hC0);
      cmd_nd(2'b01, 8'h20);
      no_busy("R12 set after lock no busy");
      read_guard(8'h7F, "R12 set after lock ignored");
      guard_sel = 1'b0;
      cmd_d(2'b01, 8'h60, 16'h6666);
      wait_ready("R12 write after lock");
      read_word(8'h60, 16'h6666, 0, "R12 guard stays off");

      ->got_ev;
      finish_run();
   end
endmodule